// File: doc/BRIEF.md
# Ethernet DMA Control and Interrupt Register Bank

This block is the software-visible control point of an Ethernet DMA engine. A host reaches it through a plain word-oriented read/write bus. It holds the bus-mode, status, interrupt-enable and operating-control words, the receive and transmit descriptor-list bases, the two current-descriptor pointers, and a fixed version word. The receive and transmit engines read their run enables, list bases and current pointers from it. They report events by pulsing status bits, and the transmit engine is woken by a poll strobe.

Each register the engines or software touch has its own update rule, and the bus decoder assigns each access to one of a small set of named targets. The targets are NONE, VERSION, BUSMODE, POLL, RXBASE, TXBASE, STATUS, CTRL, INTEN, TXCUR and RXCUR. There is no sequencing: every access completes in the cycle it is presented. Read data is registered and appears on the cycle after the read strobe. A single level interrupt is high whenever an enabled status bit is set.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every register reads zero except the version word (word 0x008), which reads 0x00001012. After reset, irq, rx_enable, tx_enable and tx_poll_kick are low.
- R2: The version word always reads 0x00001012. Writes to it have no effect.
- R3: A write to the status word (word 0x3C5) clears each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A bit pulsed on sts_set reads as 1 from the next cycle. If a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: irq is high exactly when the status word AND the interrupt-enable word (word 0x3C7) is non-zero. It follows both writes and set pulses.
- R6: Writing the receive list base (word 0x3C3) also loads the current receive pointer (word 0x3D3) with the same value. Writing the transmit list base (word 0x3C4) also loads the current transmit pointer (word 0x3D2). Each current pointer can also be written directly without changing its base.
- R7: A write to bus mode (word 0x3C0) stores the data with bit 0 forced to 0.
- R8: A write to the poll word (word 0x3C1) raises tx_poll_kick for exactly the following cycle and stores nothing. The poll word reads zero.
- R9: Control word (word 0x3C6) bit 1 drives rx_enable and bit 13 drives tx_enable.
- R10: The word index is the byte address shifted right by 2. Unassigned words and word indexes of 0x400 or more read zero, and writes to them change no register.
- R11: bus_rdata is updated only on the cycle after a read strobe and holds its value otherwise. A read returns the value held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sts_set | input | DATA_W | One-cycle status set pulses from the engines |
| irq | output | 1 | Level interrupt |
| rx_enable | output | 1 | Receive engine run enable |
| tx_enable | output | 1 | Transmit engine run enable |
| rx_list_base | output | DATA_W | Receive descriptor list base |
| tx_list_base | output | DATA_W | Transmit descriptor list base |
| rx_cur_desc | output | DATA_W | Current receive descriptor pointer |
| tx_cur_desc | output | DATA_W | Current transmit descriptor pointer |
| tx_poll_kick | output | 1 | One-cycle transmit poll strobe |

## Verification
An engine can pulse a status bit in the same cycle that software writes a one to clear that same bit. The bench provokes this by driving sts_set together with a status write, once on the same bit and once on different bits. It then judges the result by reading the status word back and watching irq, and expects the set to survive while only the other targeted bits drop. A second overlap exercised is a list-base write, which must update both the base and its current pointer in that one cycle.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VERSION,
        SEL_BUSMODE,
        SEL_POLL,
        SEL_RXBASE,
        SEL_TXBASE,
        SEL_STATUS,
        SEL_CTRL,
        SEL_INTEN,
        SEL_TXCUR,
        SEL_RXCUR
    } reg_sel_e;

    localparam int unsigned BANK_WORDS  = 32'h400;
    localparam int unsigned W_VERSION   = 32'h008;
    localparam int unsigned W_BUSMODE   = 32'h3C0;
    localparam int unsigned W_POLL      = 32'h3C1;
    localparam int unsigned W_RXBASE    = 32'h3C3;
    localparam int unsigned W_TXBASE    = 32'h3C4;
    localparam int unsigned W_STATUS    = 32'h3C5;
    localparam int unsigned W_CTRL      = 32'h3C6;
    localparam int unsigned W_INTEN     = 32'h3C7;
    localparam int unsigned W_TXCUR     = 32'h3D2;
    localparam int unsigned W_RXCUR     = 32'h3D3;

    localparam logic [31:0] VERSION_VALUE = 32'h0000_1012;
    localparam int unsigned RX_RUN_BIT = 1;
    localparam int unsigned TX_RUN_BIT = 13;

endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode
    import dmarb_pkg::*;
#(
    parameter int unsigned WORD_W = 12
) (
    input  logic [WORD_W-1:0] word_idx,
    output reg_sel_e          sel
);

    logic in_bank;
    assign in_bank = (32'(word_idx) < BANK_WORDS);

    always_comb begin
        sel = SEL_NONE;
        if (in_bank) begin
            unique case (32'(word_idx))
                W_VERSION: sel = SEL_VERSION;
                W_BUSMODE: sel = SEL_BUSMODE;
                W_POLL:    sel = SEL_POLL;
                W_RXBASE:  sel = SEL_RXBASE;
                W_TXBASE:  sel = SEL_TXBASE;
                W_STATUS:  sel = SEL_STATUS;
                W_CTRL:    sel = SEL_CTRL;
                W_INTEN:   sel = SEL_INTEN;
                W_TXCUR:   sel = SEL_TXCUR;
                W_RXCUR:   sel = SEL_RXCUR;
                default:   sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dmarb_status.sv
module dmarb_status #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] status_q
);

    logic [DATA_W-1:0] kept;
    assign kept = clr_en ? (status_q & ~clr_mask) : status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= kept | set_vec;
        end
    end

endmodule

// File: rtl/dmarb_listptr.sv
module dmarb_listptr #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic              cur_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] cur_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_we) begin
                base_q <= wdata;
                cur_q  <= wdata;
            end else if (cur_we) begin
                cur_q  <= wdata;
            end
        end
    end

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dmarb_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] sts_set,
    output logic              irq,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic [DATA_W-1:0] rx_list_base,
    output logic [DATA_W-1:0] tx_list_base,
    output logic [DATA_W-1:0] rx_cur_desc,
    output logic [DATA_W-1:0] tx_cur_desc,
    output logic              tx_poll_kick
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned NPTR   = 2;

    logic [WORD_W-1:0] word_idx;
    logic [1:0]        unused_lsb;
    reg_sel_e          sel;

    assign word_idx   = bus_addr[ADDR_W-1:2];
    assign unused_lsb = bus_addr[1:0];

    dmarb_decode #(.WORD_W(WORD_W)) u_dec (
        .word_idx (word_idx),
        .sel      (sel)
    );

    logic [DATA_W-1:0] busmode_q, ctrl_q, inten_q, status_q;
    logic              kick_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busmode_q <= '0;
            ctrl_q    <= '0;
            inten_q   <= '0;
            kick_q    <= 1'b0;
        end else begin
            kick_q <= bus_wr && (sel == SEL_POLL);
            if (bus_wr) begin
                unique case (sel)
                    SEL_BUSMODE: busmode_q <= {bus_wdata[DATA_W-1:1], 1'b0};
                    SEL_CTRL:    ctrl_q    <= bus_wdata;
                    SEL_INTEN:   inten_q   <= bus_wdata;
                    default:     ;
                endcase
            end
        end
    end

    dmarb_status #(.DATA_W(DATA_W)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (bus_wr && (sel == SEL_STATUS)),
        .clr_mask (bus_wdata),
        .set_vec  (sts_set),
        .status_q (status_q)
    );

    // index 0 = receive, index 1 = transmit
    logic [NPTR-1:0]   base_we, cur_we;
    logic [DATA_W-1:0] base_q [NPTR];
    logic [DATA_W-1:0] cur_q  [NPTR];

    assign base_we[0] = bus_wr && (sel == SEL_RXBASE);
    assign base_we[1] = bus_wr && (sel == SEL_TXBASE);
    assign cur_we[0]  = bus_wr && (sel == SEL_RXCUR);
    assign cur_we[1]  = bus_wr && (sel == SEL_TXCUR);

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dmarb_listptr #(.DATA_W(DATA_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .base_we (base_we[g]),
            .cur_we  (cur_we[g]),
            .wdata   (bus_wdata),
            .base_q  (base_q[g]),
            .cur_q   (cur_q[g])
        );
    end

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_VERSION: rd_val = DATA_W'(VERSION_VALUE);
            SEL_BUSMODE: rd_val = busmode_q;
            SEL_RXBASE:  rd_val = base_q[0];
            SEL_TXBASE:  rd_val = base_q[1];
            SEL_STATUS:  rd_val = status_q;
            SEL_CTRL:    rd_val = ctrl_q;
            SEL_INTEN:   rd_val = inten_q;
            SEL_RXCUR:   rd_val = cur_q[0];
            SEL_TXCUR:   rd_val = cur_q[1];
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

    assign irq          = |(status_q & inten_q);
    assign rx_enable    = ctrl_q[RX_RUN_BIT];
    assign tx_enable    = ctrl_q[TX_RUN_BIT];
    assign rx_list_base = base_q[0];
    assign tx_list_base = base_q[1];
    assign rx_cur_desc  = cur_q[0];
    assign tx_cur_desc  = cur_q[1];
    assign tx_poll_kick = kick_q;

endmodule

// File: rtl/dmarb_checker.sv
module dmarb_checker
    import dmarb_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] sts_set,
    input logic              irq,
    input logic              tx_poll_kick,
    input logic              rx_enable,
    input logic [DATA_W-1:0] rx_list_base,
    input logic [DATA_W-1:0] rx_cur_desc,
    input logic [DATA_W-1:0] status_q
);

    logic [ADDR_W-3:0] widx;
    logic [1:0]        unused_chk_lsb;
    logic              poll_wr, rxbase_wr;

    assign widx           = bus_addr[ADDR_W-1:2];
    assign unused_chk_lsb = bus_addr[1:0];
    assign poll_wr        = bus_wr && (32'(widx) == W_POLL);
    assign rxbase_wr      = bus_wr && (32'(widx) == W_RXBASE);

    AST_KICK_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll_kick |-> $past(poll_wr)) else $error("kick without poll"); // R8

    AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_wr && !tx_poll_kick) |=> tx_poll_kick) else $error("poll without kick"); // R8

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_set != '0) |=> ((status_q & $past(sts_set)) == $past(sts_set))) else $error("set lost"); // R4

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bus_wr || (sts_set != '0))) else $error("irq rose without cause"); // R5

    AST_BASE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        rxbase_wr |=> (rx_cur_desc == rx_list_base)) else $error("base not copied"); // R6

    AST_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(rx_enable)) else $error("enable moved without write"); // R9

endmodule

bind dma_regbank dmarb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .sts_set      (sts_set),
    .irq          (irq),
    .tx_poll_kick (tx_poll_kick),
    .rx_enable    (rx_enable),
    .rx_list_base (rx_list_base),
    .rx_cur_desc  (rx_cur_desc),
    .status_q     (status_q)
);

// File: tb/dma_regbank_test.sv
module dma_regbank_test;

    localparam int AW = 14;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] sts_set = '0;
    logic          irq, rx_enable, tx_enable, tx_poll_kick;
    logic [DW-1:0] rx_list_base, tx_list_base, rx_cur_desc, tx_cur_desc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sts_set(sts_set), .irq(irq), .rx_enable(rx_enable), .tx_enable(tx_enable),
        .rx_list_base(rx_list_base), .tx_list_base(tx_list_base),
        .rx_cur_desc(rx_cur_desc), .tx_cur_desc(tx_cur_desc),
        .tx_poll_kick(tx_poll_kick)
    );

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic          rd_seen = 1'b0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    function automatic logic [AW-1:0] byte_of(input int w);
        return AW'(w * 4);
    endfunction

    task automatic drive(input bit wr, input int w, input logic [DW-1:0] d, input logic [DW-1:0] set);
        @(posedge clk); #1;
        bus_wr = wr; bus_addr = byte_of(w); bus_wdata = d; sts_set = set;
        @(posedge clk); #1;
        bus_wr = 1'b0; sts_set = '0;
    endtask

    task automatic wr(input int w, input logic [DW-1:0] d);
        drive(1'b1, w, d, '0);
    endtask

    task automatic rd(input int w, input logic [DW-1:0] exp, input string tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = byte_of(w);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 rx_enable", rx_enable, 0);
        check("R1 tx_enable", tx_enable, 0);
        check("R1 kick", tx_poll_kick, 0);
        rd(12'h3C5, 0, "R1 status");
        rd(12'h3C6, 0, "R1 ctrl");
        rd(12'h008, 32'h1012, "R1 version");

        // R2 version fixed
        wr(12'h008, 32'hDEAD_BEEF);
        rd(12'h008, 32'h1012, "R2 version after write");

        // R7 bus mode bit 0
        wr(12'h3C0, 32'hFFFF_FFFF);
        rd(12'h3C0, 32'hFFFF_FFFE, "R7 busmode");

        // R9 run enables
        wr(12'h3C6, 32'h0000_2002);
        check("R9 rx_enable on", rx_enable, 1);
        check("R9 tx_enable on", tx_enable, 1);
        wr(12'h3C6, 32'h0000_2000);
        check("R9 rx_enable off", rx_enable, 0);
        check("R9 tx_enable kept", tx_enable, 1);

        // R6 base/current pointers
        wr(12'h3C3, 32'h0000_1000);
        check("R6 rx base", rx_list_base, 32'h1000);
        check("R6 rx cur copy", rx_cur_desc, 32'h1000);
        wr(12'h3D3, 32'h0000_1040);
        check("R6 rx cur direct", rx_cur_desc, 32'h1040);
        check("R6 rx base kept", rx_list_base, 32'h1000);
        wr(12'h3C4, 32'h0000_2000);
        check("R6 tx cur copy", tx_cur_desc, 32'h2000);
        rd(12'h3D2, 32'h2000, "R6 tx cur read");
        rd(12'h3D3, 32'h1040, "R6 rx cur read");

        // R8 poll kick
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = byte_of(12'h3C1); bus_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        check("R8 kick high", tx_poll_kick, 1);
        @(posedge clk); #1;
        check("R8 kick low", tx_poll_kick, 0);
        rd(12'h3C1, 0, "R8 poll reads zero");

        // R4/R5/R3 status and interrupt
        drive(1'b0, 0, 0, 32'h0001_0041);
        rd(12'h3C5, 32'h0001_0041, "R4 set pulses");
        check("R5 irq masked", irq, 0);
        wr(12'h3C7, 32'h0000_0040);
        check("R5 irq enabled", irq, 1);
        wr(12'h3C5, 32'h0000_0040);
        check("R5 irq after clear", irq, 0);
        rd(12'h3C5, 32'h0001_0001, "R3 w1c");
        drive(1'b1, 12'h3C5, 32'h0000_0001, 32'h0000_0001);
        rd(12'h3C5, 32'h0001_0001, "R4 set beats clear");
        drive(1'b1, 12'h3C5, 32'h0001_0000, 32'h0000_8000);
        rd(12'h3C5, 32'h0000_8001, "R3 R4 mixed");
        wr(12'h3C7, 32'h0000_8000);
        check("R5 irq abnormal", irq, 1);
        wr(12'h3C5, 32'h0000_8001);
        check("R5 irq clear all", irq, 0);

        // R10 unmapped and out of range
        wr(12'h100, 32'h1234_5678);
        rd(12'h100, 0, "R10 unmapped");
        wr(12'h7C6, 32'hFFFF_FFFF);
        check("R10 alias no effect", rx_enable, 0);
        rd(12'h7C6, 0, "R10 out of range");
        rd(12'h3C6, 32'h0000_2000, "R10 ctrl intact");

        // R11 rdata holds and read-before-write
        repeat (2) @(posedge clk);
        #1 check("R11 rdata holds", bus_rdata, 32'h0000_2000);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = byte_of(12'h3C7); bus_wdata = 32'h5;
        exp_q.push_back(32'h0000_8000); tag_q.push_back("R11 read old value");
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_wr = 1'b0;
        rd(12'h3C7, 32'h5, "R11 new value");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule